// File: doc/BRIEF.md
# Reference Clock Quality Monitor

This block judges one incoming reference clock against the nominal rate chosen for it and reports whether that reference can be trusted. The reference is brought into the fast master-clock domain through a synchronizer. Only its rising edges are used. The spacing between successive rising edges is counted in master-clock ticks and compared with windows derived from the nominal period of the selected rate. Five rates are supported: 8 kHz, 1.544 MHz, 2.048 MHz, 8.192 MHz and 16.384 MHz.

Two status flags come out. `ref_fail` is the coarse verdict. It is raised by a badly off-rate period or by a missing reference. Once raised, it is held until a run of consecutive good periods has been seen. `out_of_range` is a finer frequency check with two selectable thresholds. Both flags use hysteresis so that they do not flicker when the measured period sits near a limit. The flags only report status. The surrounding clock logic decides what to do with them.

Top module: `refclk_monitor`

## Requirements
- R1: A synchronous active-high reset clears all counters and sets both `ref_fail` and `out_of_range` to 1. The first rising edge after reset only starts timing and produces no measurement.
- R2: A measurement is the number of master-clock ticks between two successive rising edges of `ref_in`, whatever the duty cycle. `freq_sel` selects the nominal period N:
  - 0 selects 8 kHz.
  - 1 selects 1.544 MHz.
  - 2 selects 2.048 MHz.
  - 3 selects 8.192 MHz.
  - 4 selects 16.384 MHz.
  - Codes 5 to 7 use the code-0 period.
- R3: While `ref_fail` is 0, a measurement P with |P-N| > N>>2 sets `ref_fail`. A measurement within that window leaves it at 0.
- R4: While `ref_fail` is 1, a measurement counts as good only if |P-N| <= N>>3. A deviation between the two limits counts as bad.
- R5: `ref_fail` clears after REQ_N consecutive good measurements. Any bad measurement, or any loss, during requalification restarts the count from zero.
- R6: If no rising edge arrives within 2N ticks of the previous one, this counts as a loss. A loss sets both flags, and the next edge only restarts timing.
- R7: `out_of_range` is set by a measurement with |P-N| greater than the threshold T. T is N>>4 when `oor_sel`=0 and N>>3 when `oor_sel`=1.
- R8: `out_of_range` clears only on a measurement with |P-N| <= T>>1. A deviation between T>>1 and T leaves the flag unchanged.
- R9: Both flags are registered and change only in the cycle after a measurement or a loss, or in reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_in | input | 1 | Reference clock input, asynchronous to clk |
| freq_sel | input | 3 | Nominal rate code of the reference |
| oor_sel | input | 1 | Out-of-range threshold select: 0 narrow, 1 wide |
| ref_fail | output | 1 | Reference failed or not yet requalified |
| out_of_range | output | 1 | Reference period outside the selected threshold |

## Verification
The assertions check the following on every cycle:
- Either flag rises only after a measurement or a loss.
- `ref_fail` falls only on the measurement that completes the requalify run.
- The requalify counter never reaches REQ_N.
- A measurement and a loss never coincide.
- A synchronized rising edge lasts one cycle.

The numeric windows can only be shown by the directed scenarios. These cover the trip and accept limits with their hysteresis band, the restart of requalification by a bad period, the loss timeout, the two out-of-range thresholds, and the fallback for unused rate codes.

// File: rtl/refmon_pkg.sv
package refmon_pkg;

  // Nominal rate codes carried on freq_sel
  typedef enum logic [2:0] {
    RATE_8K     = 3'd0,
    RATE_1M544  = 3'd1,
    RATE_2M048  = 3'd2,
    RATE_8M192  = 3'd3,
    RATE_16M384 = 3'd4
  } ref_rate_e;

  // Absolute distance between two tick counts
  function automatic logic [31:0] tick_gap(input logic [31:0] a, input logic [31:0] b);
    return (a >= b) ? (a - b) : (b - a);
  endfunction

endpackage

// File: rtl/refmon_edge.sv
module refmon_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_in,
  output logic rise_o
);
  logic [SYNC_STAGES:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q   <= '0;
      rise_o <= 1'b0;
    end else begin
      sh_q   <= {sh_q[SYNC_STAGES-1:0], ref_in};
      rise_o <= sh_q[SYNC_STAGES-1] & ~sh_q[SYNC_STAGES];
    end
  end

  // R2: a synchronized rising edge is a single-cycle pulse
  p_rise_single_r2: assert property (@(posedge clk) disable iff (rst)
    rise_o |=> !rise_o);

endmodule

// File: rtl/refmon_meter.sv
module refmon_meter #(
  parameter int CW = 17
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rise_i,
  input  logic [CW-1:0] nom_i,
  output logic          meas_o,
  output logic [CW-1:0] period_o,
  output logic          loss_o
);
  logic [CW-1:0] cnt_q;
  logic          armed_q;
  logic [CW:0]   nxt;
  logic [CW:0]   lim;

  always_comb begin
    nxt = {1'b0, cnt_q} + 1'b1;
    lim = {nom_i, 1'b0};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      armed_q  <= 1'b0;
      meas_o   <= 1'b0;
      loss_o   <= 1'b0;
      period_o <= '0;
    end else begin
      meas_o <= 1'b0;
      loss_o <= 1'b0;
      if (rise_i) begin
        cnt_q   <= '0;
        armed_q <= 1'b1;
        if (armed_q) begin
          meas_o   <= 1'b1;
          period_o <= nxt[CW-1:0];
        end
      end else if (armed_q) begin
        if (nxt >= lim) begin
          loss_o  <= 1'b1;
          armed_q <= 1'b0;
          cnt_q   <= '0;
        end else begin
          cnt_q <= nxt[CW-1:0];
        end
      end
    end
  end

  // R2: a measurement only follows a detected rising edge
  p_meas_after_edge_r2: assert property (@(posedge clk) disable iff (rst)
    meas_o |-> $past(rise_i));
  // R6: a loss is only declared when no edge arrived
  p_loss_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    loss_o |-> !$past(rise_i));

endmodule

// File: rtl/refmon_qual.sv
module refmon_qual
  import refmon_pkg::*;
#(
  parameter int CW      = 17,
  parameter int REQ_N   = 16,
  parameter int FAIL_SH = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          meas_i,
  input  logic          loss_i,
  input  logic [CW-1:0] period_i,
  input  logic [CW-1:0] nom_i,
  output logic          fail_o
);
  localparam int RCW = $clog2(REQ_N + 1);
  localparam logic [RCW-1:0] LAST = RCW'(REQ_N - 1);

  logic [RCW-1:0] cnt_q;
  logic [31:0]    dev, trip, accept;
  logic           good;

  always_comb begin
    dev    = tick_gap(32'(period_i), 32'(nom_i));
    trip   = 32'(nom_i) >> FAIL_SH;
    accept = 32'(nom_i) >> (FAIL_SH + 1);
    good   = fail_o ? (dev <= accept) : (dev <= trip);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fail_o <= 1'b1;
      cnt_q  <= '0;
    end else if (loss_i) begin
      fail_o <= 1'b1;
      cnt_q  <= '0;
    end else if (meas_i) begin
      if (!good) begin
        fail_o <= 1'b1;
        cnt_q  <= '0;
      end else if (fail_o) begin
        if (cnt_q == LAST) begin
          fail_o <= 1'b0;
          cnt_q  <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  // R3: the fail flag rises only on a measurement or a loss
  p_fail_cause_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(fail_o) |-> $past(meas_i || loss_i));
  // R5: clearing happens only on the measurement that ends the run
  p_clear_cause_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(fail_o) |-> ($past(meas_i) && ($past(cnt_q) == LAST)));
  // R5: the run counter stays below its target
  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST);
  // R6: a loss and a measurement never arrive together
  p_excl_r6: assert property (@(posedge clk) disable iff (rst)
    $onehot0({meas_i, loss_i}));

endmodule

// File: rtl/refmon_range.sv
module refmon_range
  import refmon_pkg::*;
#(
  parameter int CW       = 17,
  parameter int OOR_SH_N = 4,
  parameter int OOR_SH_W = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          meas_i,
  input  logic          loss_i,
  input  logic [CW-1:0] period_i,
  input  logic [CW-1:0] nom_i,
  input  logic          wide_i,
  output logic          oor_o
);
  logic [31:0] dev, thr, clr;

  always_comb begin
    dev = tick_gap(32'(period_i), 32'(nom_i));
    thr = wide_i ? (32'(nom_i) >> OOR_SH_W) : (32'(nom_i) >> OOR_SH_N);
    clr = thr >> 1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      oor_o <= 1'b1;
    end else if (loss_i) begin
      oor_o <= 1'b1;
    end else if (meas_i) begin
      if (dev > thr)       oor_o <= 1'b1;
      else if (dev <= clr) oor_o <= 1'b0;
    end
  end

  // R7: the out-of-range flag rises only on a measurement or a loss
  p_oor_rise_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(oor_o) |-> $past(meas_i || loss_i));
  // R8: it falls only on a measurement, never on a loss
  p_oor_fall_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(oor_o) |-> ($past(meas_i) && !$past(loss_i)));

endmodule

// File: rtl/refclk_monitor.sv
module refclk_monitor
  import refmon_pkg::*;
#(
  parameter int NOM_8K      = 32768,
  parameter int NOM_1M544   = 170,
  parameter int NOM_2M048   = 128,
  parameter int NOM_8M192   = 32,
  parameter int NOM_16M384  = 16,
  parameter int REQ_N       = 16,
  parameter int FAIL_SH     = 2,
  parameter int OOR_SH_N    = 4,
  parameter int OOR_SH_W    = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ref_in,
  input  logic [2:0] freq_sel,
  input  logic       oor_sel,
  output logic       ref_fail,
  output logic       out_of_range
);
  // The 8 kHz period is the longest; the counter must hold twice it
  localparam int CW = $clog2(2 * NOM_8K + 1);

  logic [CW-1:0] nom_d, nom_q;
  logic          rise;
  logic          meas;
  logic          loss;
  logic [CW-1:0] period;

  always_comb begin
    case (ref_rate_e'(freq_sel))
      RATE_1M544:  nom_d = CW'(NOM_1M544);
      RATE_2M048:  nom_d = CW'(NOM_2M048);
      RATE_8M192:  nom_d = CW'(NOM_8M192);
      RATE_16M384: nom_d = CW'(NOM_16M384);
      default:     nom_d = CW'(NOM_8K);
    endcase
  end

  always_ff @(posedge clk) nom_q <= nom_d;

  refmon_edge #(.SYNC_STAGES(SYNC_STAGES)) edge_i (
    .clk(clk), .rst(rst), .ref_in(ref_in), .rise_o(rise)
  );

  refmon_meter #(.CW(CW)) meter_i (
    .clk(clk), .rst(rst), .rise_i(rise), .nom_i(nom_q),
    .meas_o(meas), .period_o(period), .loss_o(loss)
  );

  refmon_qual #(.CW(CW), .REQ_N(REQ_N), .FAIL_SH(FAIL_SH)) qual_i (
    .clk(clk), .rst(rst), .meas_i(meas), .loss_i(loss),
    .period_i(period), .nom_i(nom_q), .fail_o(ref_fail)
  );

  refmon_range #(.CW(CW), .OOR_SH_N(OOR_SH_N), .OOR_SH_W(OOR_SH_W)) range_i (
    .clk(clk), .rst(rst), .meas_i(meas), .loss_i(loss),
    .period_i(period), .nom_i(nom_q), .wide_i(oor_sel), .oor_o(out_of_range)
  );

  // R9: both flags hold steady when no event is processed
  p_stable_r9: assert property (@(posedge clk) disable iff (rst)
    (!$past(meas) && !$past(loss) && !$past(rst)) |-> ($stable(ref_fail) && $stable(out_of_range)));

endmodule

// File: tb/refclk_monitor_tb_top.sv
module refclk_monitor_tb_top;
  localparam int REQ = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ref_in = 1'b0;
  logic [2:0] freq_sel = 3'd2;
  logic       oor_sel = 1'b0;
  logic       ref_fail, out_of_range;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  refclk_monitor #(
    .NOM_8K(400), .NOM_1M544(160), .NOM_2M048(128), .NOM_8M192(32),
    .NOM_16M384(16), .REQ_N(REQ)
  ) dut_i (
    .clk(clk), .rst(rst), .ref_in(ref_in), .freq_sel(freq_sel),
    .oor_sel(oor_sel), .ref_fail(ref_fail), .out_of_range(out_of_range)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  // n rising edges spaced p ticks apart, high for hi ticks
  task automatic send_duty(input int n, input int p, input int hi);
    for (int i = 0; i < n; i++) begin
      ref_in = 1'b1;
      repeat (hi) @(negedge clk);
      ref_in = 1'b0;
      repeat (p - hi) @(negedge clk);
    end
  endtask

  task automatic send(input int n, input int p);
    send_duty(n, p, p / 2);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 fail after reset", ref_fail, 1'b1);
    check("R1 oor after reset", out_of_range, 1'b1);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    send(1, 128);
    check("R1 first edge gives no clear", ref_fail, 1'b1);
  endtask

  task automatic t_qualify;
    send(REQ - 1, 128);
    check("R5 one short of requalify", ref_fail, 1'b1);
    send(1, 128);
    check("R5 requalified", ref_fail, 1'b0);
    check("R8 oor cleared on exact period", out_of_range, 1'b0);
  endtask

  task automatic t_duty;
    send_duty(2, 128, 100);
    check("R2 duty cycle ignored fail", ref_fail, 1'b0);
    check("R2 duty cycle ignored oor", out_of_range, 1'b0);
  endtask

  task automatic t_oor;
    oor_sel = 1'b0;
    send(2, 140);
    check("R7 narrow threshold trips", out_of_range, 1'b1);
    check("R3 small deviation keeps pass", ref_fail, 1'b0);
    oor_sel = 1'b1;
    send(2, 140);
    check("R8 hysteresis holds oor", out_of_range, 1'b1);
    send(2, 132);
    check("R8 clears inside half threshold", out_of_range, 1'b0);
    send(2, 140);
    check("R7 wide threshold passes", out_of_range, 1'b0);
    oor_sel = 1'b0;
    send(2, 140);
    check("R7 narrow threshold again", out_of_range, 1'b1);
    send(2, 128);
    check("R8 clear at nominal", out_of_range, 1'b0);
  endtask

  task automatic t_fail_hyst;
    send(2, 150);
    check("R3 within trip window", ref_fail, 1'b0);
    send(2, 170);
    check("R3 trip on large deviation", ref_fail, 1'b1);
    send(REQ + 2, 150);
    check("R4 band deviation not good", ref_fail, 1'b1);
    send(3, 128);
    send(2, 150);
    send(3, 128);
    check("R5 bad period restarts run", ref_fail, 1'b1);
    send(2, 128);
    check("R5 clears after full run", ref_fail, 1'b0);
  endtask

  task automatic t_loss;
    repeat (300) @(negedge clk);
    check("R6 loss sets fail", ref_fail, 1'b1);
    check("R6 loss sets oor", out_of_range, 1'b1);
    send(REQ, 128);
    check("R6 first edge after loss not measured", ref_fail, 1'b1);
    send(1, 128);
    check("R6 requalify after loss", ref_fail, 1'b0);
  endtask

  task automatic t_freq;
    freq_sel = 3'd4;
    repeat (10) @(negedge clk);
    check("R2 new rate window applies", ref_fail, 1'b1);
    send(REQ, 16);
    check("R2 16 MHz requal pending", ref_fail, 1'b1);
    send(1, 16);
    check("R2 16 MHz qualified", ref_fail, 1'b0);
    check("R2 16 MHz in range", out_of_range, 1'b0);
    freq_sel = 3'd7;
    send(2, 16);
    check("R2 unused code uses 8 kHz period", ref_fail, 1'b1);
    send(REQ + 1, 400);
    check("R2 unused code qualifies at 8 kHz", ref_fail, 1'b0);
  endtask

  task automatic t_rst_mid;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 mid-run reset fail", ref_fail, 1'b1);
    check("R1 mid-run reset oor", out_of_range, 1'b1);
    rst = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_qualify();
    t_duty();
    t_oor();
    t_fail_hyst();
    t_loss();
    t_freq();
    t_rst_mid();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule